// File: doc/BRIEF.md
# Paged NIC command register bank

This block is the host-facing register file of a small network controller. The host reaches sixteen byte-wide offsets through an address, read and write strobes, and separate 8-bit write and read data buses. A command register at offset 0 is visible on every page. Its two top bits pick which of four register pages the other fifteen offsets reach. At several offsets a read and a write reach different registers: a read returns live status from the datapath, and a write loads a configuration register.

The command register also drives the controller. It holds stop and start bits, a transmit request bit and a 3-bit remote DMA command. The block turns writes to these bits into one-cycle pulses and held levels for the transmit and DMA engines. It takes done indications back from those engines and follows its own rules for clearing the command bits. It also reports when the controller has reached its stopped state after a stop request.

Top module: `nic_cmd_regbank`

## Requirements
- R1: After reset the command register reads 0x21: stop set, start clear, transmit request clear, remote DMA command 100, page 0. The reset status output is 1, the online output is 0 and all six configuration registers are 0.
- R2: A write to offset 0 on any page, including page 3, loads the page number from write-data bits 7:6 (00 page 0, 01 page 1, 10 page 2, 11 page 3). Offset 0 always reads back the command register.
- R3: On page 0, a write to offset 1 loads the page-start register and a write to offset 2 loads the page-stop register. A read of offset 1 returns local address bits 7:0 and a read of offset 2 returns bits 15:8. On page 2, offsets 1 and 2 read back page-start and page-stop. A write to them raises the local-address load strobe for the low or high byte in that same cycle and leaves page-start and page-stop unchanged.
- R4: On page 0, writes to offsets 0xC, 0xD, 0xE and 0xF load the receive, transmit and data configuration registers and the interrupt mask. Reads of those offsets return receive status and tally counters 0, 1 and 2. On page 2, reads of 0xC to 0xF return the four configuration registers.
- R5: On pages 1 and 3, every offset other than 0 reads as 0 and ignores writes. Offsets 3 to 0xB read as 0 on every page. With the read strobe low, read data is 0.
- R6: The online output is high only when start (bit 1) is set and stop (bit 0) is clear. While stop is set, the reset status output rises on the first clock edge at which the busy input is low, and never while busy is high. A command write with start set and stop clear clears it.
- R7: Writing 1 to bit 2 sets the transmit request. If the request was clear, the write also raises the transmit start output for the one following cycle. Writing 0 to bit 2 has no effect. The transmit-done input clears the request, but a write setting it in the same cycle takes priority.
- R8: Writing a non-zero value to bits 5:3 loads the remote DMA command and raises the DMA command pulse for the one following cycle. Writing 000 leaves the field unchanged and produces no pulse. The command is driven on the DMA command output.
- R9: When the DMA-done input arrives while the command's bit 2 is 0 (read 001, write 010, send 011), the field returns to 100 on the next edge. A held abort (1xx) ignores DMA-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| busy_i | input | 1 | Reception or transmission in progress |
| tx_done_i | input | 1 | Transmission completed or aborted |
| dma_done_i | input | 1 | Remote DMA completed |
| rx_status_i | input | 8 | Receive status value |
| tally0_i | input | 8 | Tally counter 0 |
| tally1_i | input | 8 | Tally counter 1 |
| tally2_i | input | 8 | Tally counter 2 |
| local_addr_i | input | 16 | Current local DMA address |
| online_o | output | 1 | Controller enabled |
| reset_stat_o | output | 1 | Controller has reached the stopped state |
| tx_start_o | output | 1 | One-cycle transmit start pulse |
| dma_cmd_pulse_o | output | 1 | One-cycle remote DMA command pulse |
| dma_cmd_o | output | 3 | Current remote DMA command |
| ldma_lo_we_o | output | 1 | Load local address low byte from wdata |
| ldma_hi_we_o | output | 1 | Load local address high byte from wdata |
| page_start_o | output | 8 | Page-start register |
| page_stop_o | output | 8 | Page-stop register |
| rx_cfg_o | output | 8 | Receive configuration |
| tx_cfg_o | output | 8 | Transmit configuration |
| data_cfg_o | output | 8 | Data configuration |
| int_mask_o | output | 8 | Interrupt mask |

## Verification
Several rules are checked on every cycle. Page 3 reads return zero. The page bits change only after a command write. Reset status rises only from stop with no activity in progress. Transmit-done clears the request unless a write sets it again. Every DMA pulse traces back to a non-zero command write, and DMA-done returns an active command to 100. The directed scenarios cover what needs a sequence of stimulus: how each offset splits between read and write on each page, that writes to pages 1 and 3 are dropped (checked through the configuration outputs), that a 000 command write is ignored, and the exact cycle in which each pulse and level changes.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int LADDR_W = 16;
    localparam int NCFG    = 6;

    typedef struct packed {
        logic [1:0] page;
        logic [2:0] rdma;
        logic       txp;
        logic       sta;
        logic       stp;
    } cmd_reg_t;

    localparam cmd_reg_t CMD_RESET = '{page: 2'b00, rdma: 3'b100, txp: 1'b0, sta: 1'b0, stp: 1'b1};

    localparam logic [1:0] PG0 = 2'd0;
    localparam logic [1:0] PG1 = 2'd1;
    localparam logic [1:0] PG2 = 2'd2;
    localparam logic [1:0] PG3 = 2'd3;

    // configuration register index -> offset written on page 0
    // 0 page start, 1 page stop, 2 rx cfg, 3 tx cfg, 4 data cfg, 5 int mask
    function automatic logic [ADDR_W-1:0] cfg_offset(input int idx);
        if (idx < 2) return ADDR_W'(idx + 1);
        return ADDR_W'(idx + 10);
    endfunction
endpackage

// File: rtl/nic_reg_decode.sv
module nic_reg_decode
    import nic_regbank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NC = NCFG
) (
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [1:0]    page,
    output logic          cr_we,
    output logic [NC-1:0] cfg_we,
    output logic [1:0]    ldma_we
);
    assign cr_we = wr_en && (addr == '0);

    for (genvar i = 0; i < NC; i++) begin : g_cfg_we
        assign cfg_we[i] = wr_en && (page == PG0) && (addr == AW'(cfg_offset(i)));
    end

    for (genvar j = 0; j < 2; j++) begin : g_ldma_we
        assign ldma_we[j] = wr_en && (page == PG2) && (addr == AW'(j + 1));
    end
endmodule

// File: rtl/nic_cfg_bank.sv
module nic_cfg_bank
    import nic_regbank_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NC = NCFG
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NC-1:0]         we,
    input  logic [DW-1:0]         wdata,
    output logic [NC-1:0][DW-1:0] regs
);
    typedef struct packed {
        logic [NC-1:0][DW-1:0] r;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NC; i++) begin
            if (we[i]) st_d.r[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs = st_q.r;
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
    import nic_regbank_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cr_we,
    input  logic [DW-1:0] wdata,
    input  logic          busy_i,
    input  logic          tx_done_i,
    input  logic          dma_done_i,
    output cmd_reg_t      cr,
    output logic          reset_stat,
    output logic          tx_start,
    output logic          dma_pulse
);
    typedef struct packed {
        cmd_reg_t cr;
        logic     rst_stat;
        logic     tx_start;
        logic     dma_pulse;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    cmd_reg_t    wr_cr;

    assign wr_cr = cmd_reg_t'(wdata[7:0]);

    always_comb begin
        st_d           = st_q;
        st_d.tx_start  = 1'b0;
        st_d.dma_pulse = 1'b0;

        // completion from the engines
        if (tx_done_i) st_d.cr.txp = 1'b0;
        if (dma_done_i && !st_q.cr.rdma[2]) st_d.cr.rdma = 3'b100;

        // stopped-state indication once activity has drained
        if (st_q.cr.stp && !busy_i) st_d.rst_stat = 1'b1;

        if (cr_we) begin
            st_d.cr.page = wr_cr.page;
            st_d.cr.stp  = wr_cr.stp;
            st_d.cr.sta  = wr_cr.sta;
            if (wr_cr.txp) begin
                st_d.cr.txp   = 1'b1;
                st_d.tx_start = !st_q.cr.txp;
            end
            if (wr_cr.rdma != 3'b000) begin
                st_d.cr.rdma   = wr_cr.rdma;
                st_d.dma_pulse = 1'b1;
            end
            if (wr_cr.sta && !wr_cr.stp) st_d.rst_stat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cr        <= CMD_RESET;
            st_q.rst_stat  <= 1'b1;
            st_q.tx_start  <= 1'b0;
            st_q.dma_pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cr         = st_q.cr;
    assign reset_stat = st_q.rst_stat;
    assign tx_start   = st_q.tx_start;
    assign dma_pulse  = st_q.dma_pulse;
endmodule

// File: rtl/nic_cmd_regbank.sv
module nic_cmd_regbank
    import nic_regbank_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int LAW = LADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic           busy_i,
    input  logic           tx_done_i,
    input  logic           dma_done_i,
    input  logic [DW-1:0]  rx_status_i,
    input  logic [DW-1:0]  tally0_i,
    input  logic [DW-1:0]  tally1_i,
    input  logic [DW-1:0]  tally2_i,
    input  logic [LAW-1:0] local_addr_i,
    output logic           online_o,
    output logic           reset_stat_o,
    output logic           tx_start_o,
    output logic           dma_cmd_pulse_o,
    output logic [2:0]     dma_cmd_o,
    output logic           ldma_lo_we_o,
    output logic           ldma_hi_we_o,
    output logic [DW-1:0]  page_start_o,
    output logic [DW-1:0]  page_stop_o,
    output logic [DW-1:0]  rx_cfg_o,
    output logic [DW-1:0]  tx_cfg_o,
    output logic [DW-1:0]  data_cfg_o,
    output logic [DW-1:0]  int_mask_o
);
    localparam int HALF = LAW / 2;

    cmd_reg_t              cr;
    logic [7:0]            cr_bits;
    logic                  cr_we;
    logic [NCFG-1:0]       cfg_we;
    logic [1:0]            ldma_we;
    logic [NCFG-1:0][DW-1:0] cfg;
    logic [DW-1:0]         rd_mux;

    assign cr_bits = cr;

    nic_reg_decode #(.AW(AW), .NC(NCFG)) u_decode (
        .addr    (addr),
        .wr_en   (wr_en),
        .page    (cr.page),
        .cr_we   (cr_we),
        .cfg_we  (cfg_we),
        .ldma_we (ldma_we)
    );

    nic_cmd_ctrl #(.DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cr_we      (cr_we),
        .wdata      (wdata),
        .busy_i     (busy_i),
        .tx_done_i  (tx_done_i),
        .dma_done_i (dma_done_i),
        .cr         (cr),
        .reset_stat (reset_stat_o),
        .tx_start   (tx_start_o),
        .dma_pulse  (dma_cmd_pulse_o)
    );

    nic_cfg_bank #(.DW(DW), .NC(NCFG)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (wdata),
        .regs  (cfg)
    );

    always_comb begin
        rd_mux = '0;
        if (addr == '0) begin
            rd_mux = DW'(cr_bits);
        end else begin
            unique case (cr.page)
                PG0: begin
                    case (addr)
                        AW'(1):  rd_mux = DW'(local_addr_i[HALF-1:0]);
                        AW'(2):  rd_mux = DW'(local_addr_i[LAW-1:HALF]);
                        AW'(12): rd_mux = rx_status_i;
                        AW'(13): rd_mux = tally0_i;
                        AW'(14): rd_mux = tally1_i;
                        AW'(15): rd_mux = tally2_i;
                        default: rd_mux = '0;
                    endcase
                end
                PG2: begin
                    for (int i = 0; i < NCFG; i++) begin
                        if (addr == AW'(cfg_offset(i))) rd_mux = cfg[i];
                    end
                end
                default: rd_mux = '0;
            endcase
        end
    end

    assign rdata        = rd_en ? rd_mux : '0;
    assign online_o     = cr.sta && !cr.stp;
    assign dma_cmd_o    = cr.rdma;
    assign ldma_lo_we_o = ldma_we[0];
    assign ldma_hi_we_o = ldma_we[1];
    assign page_start_o = cfg[0];
    assign page_stop_o  = cfg[1];
    assign rx_cfg_o     = cfg[2];
    assign tx_cfg_o     = cfg[3];
    assign data_cfg_o   = cfg[4];
    assign int_mask_o   = cfg[5];
endmodule

// File: rtl/nic_cmd_regbank_chk.sv
module nic_cmd_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       busy_i,
    input logic       tx_done_i,
    input logic       dma_done_i,
    input logic       reset_stat_o,
    input logic       tx_start_o,
    input logic       dma_cmd_pulse_o,
    input logic [2:0] dma_cmd_o,
    input logic [7:0] cr_bits
);
    p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && addr == 4'd0) |-> $stable(cr_bits[7:6]));

    p_page3_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cr_bits[7:6] == 2'b11 && addr != 4'd0) |-> rdata == 8'h00);

    p_rst_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_stat_o) |-> $past(cr_bits[0] && !busy_i));

    p_txp_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_i && !(wr_en && addr == 4'd0 && wdata[2])) |=> !cr_bits[2]);

    p_txstart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |-> cr_bits[2]);

    p_dma_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cmd_pulse_o |-> $past(wr_en && addr == 4'd0 && wdata[5:3] != 3'b000));

    p_dma_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done_i && !dma_cmd_o[2] && !(wr_en && addr == 4'd0 && wdata[5:3] != 3'b000))
        |=> dma_cmd_o == 3'b100);
endmodule

bind nic_cmd_regbank nic_cmd_regbank_chk u_chk (.*);

// File: tb/nic_cmd_regbank_bench.sv
module nic_cmd_regbank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy_i = 1'b0;
    logic        tx_done_i = 1'b0;
    logic        dma_done_i = 1'b0;
    logic [7:0]  rx_status_i = 8'h01;
    logic [7:0]  tally0_i = 8'h11;
    logic [7:0]  tally1_i = 8'h22;
    logic [7:0]  tally2_i = 8'h33;
    logic [15:0] local_addr_i = 16'hBEEF;
    logic        online_o, reset_stat_o, tx_start_o, dma_cmd_pulse_o;
    logic [2:0]  dma_cmd_o;
    logic        ldma_lo_we_o, ldma_hi_we_o;
    logic [7:0]  page_start_o, page_stop_o, rx_cfg_o, tx_cfg_o, data_cfg_o, int_mask_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_cmd_regbank u_nic_cmd_regbank (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(4'd0, v);
        check("R1 cr", 16'(v), 16'h21);
        check("R1 rst_stat", 16'(reset_stat_o), 16'd1);
        check("R1 online", 16'(online_o), 16'd0);
        check("R1 cfg", 16'({page_start_o, rx_cfg_o} | {int_mask_o, data_cfg_o}), 16'd0);
        check("R1 dma", 16'(dma_cmd_o), 16'd4);
        addr = 4'd0;
        #1;
        check("R5 rd_en low", 16'(rdata), 16'd0);
    endtask

    task automatic t_page0;
        logic [7:0] v;
        wr(4'd0, 8'h22);
        wr(4'd1, 8'h46); wr(4'd2, 8'h80);
        wr(4'd12, 8'h0C); wr(4'd13, 8'h02); wr(4'd14, 8'h48); wr(4'd15, 8'h7F);
        check("R3 pstart", 16'(page_start_o), 16'h46);
        check("R3 pstop", 16'(page_stop_o), 16'h80);
        check("R4 cfg", {rx_cfg_o, tx_cfg_o}, 16'h0C02);
        check("R4 cfg2", {data_cfg_o, int_mask_o}, 16'h487F);
        rd(4'd1, v); check("R3 ladr lo", 16'(v), 16'hEF);
        rd(4'd2, v); check("R3 ladr hi", 16'(v), 16'hBE);
        rd(4'd12, v); check("R4 rxstat", 16'(v), 16'h01);
        rd(4'd13, v); check("R4 tally0", 16'(v), 16'h11);
        rd(4'd14, v); check("R4 tally1", 16'(v), 16'h22);
        rd(4'd15, v); check("R4 tally2", 16'(v), 16'h33);
        rd(4'd5, v); check("R5 unused off", 16'(v), 16'h00);
    endtask

    task automatic t_page2;
        logic [7:0] v;
        wr(4'd0, 8'hA2);
        rd(4'd0, v); check("R2 cr page2", 16'(v), 16'hA2);
        rd(4'd1, v); check("R3 p2 pstart", 16'(v), 16'h46);
        rd(4'd2, v); check("R3 p2 pstop", 16'(v), 16'h80);
        rd(4'd12, v); check("R4 p2 rcr", 16'(v), 16'h0C);
        rd(4'd13, v); check("R4 p2 tcr", 16'(v), 16'h02);
        rd(4'd14, v); check("R4 p2 dcr", 16'(v), 16'h48);
        rd(4'd15, v); check("R4 p2 imr", 16'(v), 16'h7F);
        @(negedge clk);
        addr = 4'd1; wdata = 8'h99; wr_en = 1'b1;
        #1;
        check("R3 ldma lo", {8'(ldma_lo_we_o), 8'(ldma_hi_we_o)}, 16'h0100);
        addr = 4'd2;
        #1;
        check("R3 ldma hi", {8'(ldma_lo_we_o), 8'(ldma_hi_we_o)}, 16'h0001);
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 pstart kept", {page_start_o, page_stop_o}, 16'h4680);
        wr(4'd12, 8'hFF);
        check("R4 p2 write ignored", 16'(rx_cfg_o), 16'h0C);
    endtask

    task automatic t_page13;
        logic [7:0] v;
        wr(4'd0, 8'h62);
        rd(4'd0, v); check("R2 cr page1", 16'(v), 16'h62);
        rd(4'd1, v); check("R5 p1 zero", 16'(v), 16'h00);
        wr(4'd13, 8'h55);
        check("R5 p1 ignored", 16'(tx_cfg_o), 16'h02);
        wr(4'd0, 8'hE2);
        rd(4'd0, v); check("R2 cr page3", 16'(v), 16'hE2);
        rd(4'd12, v); check("R5 p3 zero", 16'(v), 16'h00);
        wr(4'd14, 8'h55);
        check("R5 p3 ignored", 16'(data_cfg_o), 16'h48);
        wr(4'd0, 8'h22);
        rd(4'd0, v); check("R2 back to page0", 16'(v), 16'h22);
    endtask

    task automatic t_stop_start;
        check("R6 online", 16'(online_o), 16'd1);
        check("R6 rst cleared", 16'(reset_stat_o), 16'd0);
        busy_i = 1'b1;
        wr(4'd0, 8'h21);
        check("R6 offline", 16'(online_o), 16'd0);
        repeat (3) @(negedge clk);
        check("R6 rst held busy", 16'(reset_stat_o), 16'd0);
        busy_i = 1'b0;
        @(negedge clk);
        check("R6 rst rises", 16'(reset_stat_o), 16'd1);
        wr(4'd0, 8'h23);
        check("R6 both set keeps rst", 16'(reset_stat_o), 16'd1);
        wr(4'd0, 8'h22);
        check("R6 start clears rst", {8'(reset_stat_o), 8'(online_o)}, 16'h0001);
    endtask

    task automatic t_tx;
        logic [7:0] v;
        wr(4'd0, 8'h26);
        check("R7 tx_start pulse", 16'(tx_start_o), 16'd1);
        @(negedge clk);
        check("R7 tx_start one cycle", 16'(tx_start_o), 16'd0);
        wr(4'd0, 8'h22);
        rd(4'd0, v); check("R7 write0 no effect", 16'(v[2]), 16'd1);
        @(negedge clk);
        tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
        rd(4'd0, v); check("R7 done clears", 16'(v[2]), 16'd0);
        @(negedge clk);
        addr = 4'd0; wdata = 8'h26; wr_en = 1'b1; tx_done_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tx_done_i = 1'b0;
        rd(4'd0, v); check("R7 write wins", 16'(v[2]), 16'd1);
        tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
    endtask

    task automatic t_dma;
        wr(4'd0, 8'h0A);
        check("R8 pulse", {8'(dma_cmd_pulse_o), 8'(dma_cmd_o)}, 16'h0101);
        @(negedge clk);
        check("R8 pulse one cycle", {8'(dma_cmd_pulse_o), 8'(dma_cmd_o)}, 16'h0001);
        wr(4'd0, 8'h02);
        check("R8 000 ignored", {8'(dma_cmd_pulse_o), 8'(dma_cmd_o)}, 16'h0001);
        @(negedge clk);
        dma_done_i = 1'b1;
        @(negedge clk);
        dma_done_i = 1'b0;
        check("R9 done to abort", 16'(dma_cmd_o), 16'd4);
        wr(4'd0, 8'h1A);
        check("R8 send packet", {8'(dma_cmd_pulse_o), 8'(dma_cmd_o)}, 16'h0103);
        wr(4'd0, 8'h32);
        check("R8 abort", {8'(dma_cmd_pulse_o), 8'(dma_cmd_o)}, 16'h0106);
        @(negedge clk);
        dma_done_i = 1'b1;
        @(negedge clk);
        dma_done_i = 1'b0;
        check("R9 abort held", 16'(dma_cmd_o), 16'd6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_page0;
        t_page2;
        t_page13;
        t_stop_start;
        t_tx;
        t_dma;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule